// File: doc/BRIEF.md
# Way-Predicted Pseudo-Associative Tag Lookup Controller

This block is the tag side of a small cache that probes one tag per cycle, in sequence. Each line of the tag store holds a valid bit and a key. A request first compares a single line. A match there is a fast hit, reported one cycle after the request is accepted. If that first line misses, the controller compares the other line of the same pair in the next cycle. A match there is a slow hit, reported two cycles after acceptance. If neither line matches, the controller reports a miss at the same point. It then asks the next level for the block over a plain request/acknowledge pair. The tag store is updated when the acknowledge arrives.

A parameter picks one of two organisations. In way-predicted mode the store is two-way set-associative, and a prediction bit per set picks the way probed first. A slow hit flips that bit. In pseudo-associative mode the store is direct-mapped. The first probe goes to the line named by the index, and the second goes to the line whose index has its top bit inverted. A slow hit swaps the two lines, so the block sits at its primary line from then on.

On a miss, both modes put the new block in the first-probed line. The block that was there moves to the other line, and whatever the other line held is dropped. Every result carries the line number of the block after the update, so a data array can follow the lookup.

Top module: `wpc_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high and `done`, `mem_req` are low, so the first access to any address is a miss.
- R2: The first probe compares exactly one line. In way-predicted mode this is line {pred[set], set}; in pseudo-associative mode it is line index. On a match, `done` and `fast_hit` are high in the cycle after acceptance, and `resp_line` is that line.
- R3: If the first probe fails, the second probe compares the other line of the pair. In way-predicted mode this is {~pred[set], set}; in pseudo-associative mode it is the index with bit SET_W-1 inverted. On a match, `done` and `slow_hit` are high two cycles after acceptance.
- R4: If both probes fail, `done` and `miss` are high two cycles after acceptance. From that cycle `mem_req` is high, `mem_addr` holds the missed address and `req_ready` is low, until the cycle after `mem_ack` is sampled high.
- R5: While `done` is high, exactly one of `fast_hit`, `slow_hit`, `miss` is high; while `done` is low, all three are low.
- R6: In way-predicted mode a slow hit flips the set's prediction bit, so repeating the same address next is a fast hit and `resp_line` names the way that hit.
- R7: In pseudo-associative mode a slow hit swaps the two lines of the pair, so `resp_line` is the primary line and repeating the address next is a fast hit.
- R8: When the refill is acknowledged, the missed block is written valid into the first-probed line. The previous content of that line moves to the second line, and the previous content of the second line is lost. `resp_line` on a miss is the first-probed line.
- R9: `resp_line` (SET_W+1 bits) gives the line that holds the requested block after the access. In way-predicted mode it is {way, set}; in pseudo-associative mode it is the line index with the top bit zero.
- R10: A request offered while `req_ready` is low is not accepted. It produces no result and does not change `mem_addr` or the tag or prediction state.
- R11: The set (or line index) is req_addr[SET_W-1:0], and the stored key is req_addr[ADDR_W-1:SET_W-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, taken when req_ready is high |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle pulse: result flags are valid |
| fast_hit | output | 1 | Block found by the first probe |
| slow_hit | output | 1 | Block found by the second probe |
| miss | output | 1 | Block found by neither probe |
| resp_line | output | SET_W+1 | Line holding the block after the update |
| mem_req | output | 1 | Refill request to the next level |
| mem_addr | output | ADDR_W | Address being refilled |
| mem_ack | input | 1 | Refill completed by the next level |

## Verification
The bench builds two copies with ADDR_W=6 and SET_W=2: one in way-predicted mode (eight lines, four prediction bits) and one in pseudo-associative mode (four lines forming two pairs). With only 64 addresses, full forward and reverse sweeps are cheap. A long pseudo-random run then keeps reaching every mix of predicted-way hits, wrong-way hits, swaps, displacements and drops. A small arithmetic model of line contents and prediction bits gives every expected outcome, latency and line number. Hand-worked sequences pin down flip, swap, displacement and the index-bit pairing with literal values.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROBE2 = 2'd1,
      ST_REFILL = 2'd2
   } wpc_state_e;

endpackage

// File: rtl/wpc_pred_bits.sv
module wpc_pred_bits #(
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic             rd_pred,
   input  logic             flip_en,
   input  logic [SET_W-1:0] flip_set
);
   localparam int NSETS = 1 << SET_W;

   logic [NSETS-1:0] pred_q;

   assign rd_pred = pred_q[rd_set];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_q <= '0;
      end else if (flip_en) begin
         pred_q[flip_set] <= ~pred_q[flip_set];
      end
   end
endmodule

// File: rtl/wpc_probe_map.sv
module wpc_probe_map #(
   parameter int ADDR_W = 10,
   parameter int SET_W  = 4,
   parameter bit PSEUDO = 1'b0,
   localparam int KEY_W  = ADDR_W - SET_W + 1,
   localparam int LINE_W = PSEUDO ? SET_W : SET_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              pred,
   output logic [SET_W-1:0]  set,
   output logic [KEY_W-1:0]  key,
   output logic [LINE_W-1:0] first_line,
   output logic [LINE_W-1:0] second_line
);
   assign set = addr[SET_W-1:0];
   assign key = addr[ADDR_W-1:SET_W-1];

   generate
      if (PSEUDO) begin : g_pseudo
         localparam logic [SET_W-1:0] TOP_BIT = SET_W'(1) << (SET_W - 1);
         logic unused_pred;
         assign unused_pred = pred;
         assign first_line  = set;
         assign second_line = set ^ TOP_BIT;
      end else begin : g_way
         assign first_line  = {pred, set};
         assign second_line = {~pred, set};
      end
   endgenerate
endmodule

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
   parameter int KEY_W  = 8,
   parameter int LINE_W = 5,
   localparam int LINES = 1 << LINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] rd_line,
   output logic              rd_valid,
   output logic [KEY_W-1:0]  rd_key,
   input  logic              wa_en,
   input  logic [LINE_W-1:0] wa_line,
   input  logic              wa_valid,
   input  logic [KEY_W-1:0]  wa_key,
   input  logic              wb_en,
   input  logic [LINE_W-1:0] wb_line,
   input  logic              wb_valid,
   input  logic [KEY_W-1:0]  wb_key
);
   logic [LINES-1:0] vld_q;
   logic [KEY_W-1:0] key_q [LINES];

   assign rd_valid = vld_q[rd_line];
   assign rd_key   = key_q[rd_line];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            vld_q[i] <= 1'b0;
            key_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (wa_en && wa_line == LINE_W'(i)) begin
               vld_q[i] <= wa_valid;
               key_q[i] <= wa_key;
            end else if (wb_en && wb_line == LINE_W'(i)) begin
               vld_q[i] <= wb_valid;
               key_q[i] <= wb_key;
            end
         end
      end
   end
endmodule

// File: rtl/wpc_lookup.sv
module wpc_lookup #(
   parameter int ADDR_W = 10,
   parameter int SET_W  = 4,
   parameter bit PSEUDO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              done,
   output logic              fast_hit,
   output logic              slow_hit,
   output logic              miss,
   output logic [SET_W:0]    resp_line,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack
);
   import wpc_pkg::*;

   localparam int KEY_W  = ADDR_W - SET_W + 1;
   localparam int LINE_W = PSEUDO ? SET_W : SET_W + 1;
   localparam int RESP_W = SET_W + 1;

   generate
      if (SET_W < 1 || ADDR_W <= SET_W) begin : g_bad_cfg
         $error("wpc_lookup: need SET_W >= 1 and ADDR_W > SET_W");
      end
   endgenerate

   wpc_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LINE_W-1:0] first_q, second_q;
   logic              first_v_q;
   logic [KEY_W-1:0]  first_key_q;
   logic              done_q, fast_q, slow_q, miss_q;
   logic [LINE_W-1:0] resp_q;

   logic [ADDR_W-1:0] map_addr;
   logic [SET_W-1:0]  map_set;
   logic [KEY_W-1:0]  map_key;
   logic [LINE_W-1:0] map_first, map_second;
   logic              pred;
   logic [LINE_W-1:0] rd_line;
   logic              rd_valid;
   logic [KEY_W-1:0]  rd_key;
   logic              tag_match;
   logic              accept;
   logic              swap_en;
   logic              fill_en;
   logic              upd_en;

   assign map_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
   assign rd_line   = (state_q == ST_IDLE) ? map_first : second_q;
   assign tag_match = rd_valid && (rd_key == map_key);
   assign accept    = req_valid && (state_q == ST_IDLE);
   assign fill_en   = (state_q == ST_REFILL) && mem_ack;
   assign upd_en    = fill_en || swap_en;

   wpc_probe_map #(
      .ADDR_W (ADDR_W),
      .SET_W  (SET_W),
      .PSEUDO (PSEUDO)
   ) u_map (
      .addr        (map_addr),
      .pred        (pred),
      .set         (map_set),
      .key         (map_key),
      .first_line  (map_first),
      .second_line (map_second)
   );

   generate
      if (PSEUDO) begin : g_pseudo
         logic unused_set;
         assign unused_set = ^map_set;
         assign pred       = 1'b0;
         assign swap_en    = (state_q == ST_PROBE2) && tag_match;
      end else begin : g_way
         wpc_pred_bits #(
            .SET_W (SET_W)
         ) u_pred (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (map_set),
            .rd_pred  (pred),
            .flip_en  ((state_q == ST_PROBE2) && tag_match),
            .flip_set (map_set)
         );
         assign swap_en = 1'b0;
      end
   endgenerate

   wpc_tag_store #(
      .KEY_W  (KEY_W),
      .LINE_W (LINE_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_line  (rd_line),
      .rd_valid (rd_valid),
      .rd_key   (rd_key),
      .wa_en    (upd_en),
      .wa_line  (first_q),
      .wa_valid (1'b1),
      .wa_key   (map_key),
      .wb_en    (upd_en),
      .wb_line  (second_q),
      .wb_valid (first_v_q),
      .wb_key   (first_key_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         first_q     <= '0;
         second_q    <= '0;
         first_v_q   <= 1'b0;
         first_key_q <= '0;
         done_q      <= 1'b0;
         fast_q      <= 1'b0;
         slow_q      <= 1'b0;
         miss_q      <= 1'b0;
         resp_q      <= '0;
      end else begin
         done_q <= 1'b0;
         fast_q <= 1'b0;
         slow_q <= 1'b0;
         miss_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q      <= req_addr;
                  first_q     <= map_first;
                  second_q    <= map_second;
                  first_v_q   <= rd_valid;
                  first_key_q <= rd_key;
                  if (tag_match) begin
                     done_q <= 1'b1;
                     fast_q <= 1'b1;
                     resp_q <= map_first;
                  end else begin
                     state_q <= ST_PROBE2;
                  end
               end
            end
            ST_PROBE2: begin
               done_q <= 1'b1;
               if (tag_match) begin
                  slow_q  <= 1'b1;
                  resp_q  <= PSEUDO ? first_q : second_q;
                  state_q <= ST_IDLE;
               end else begin
                  miss_q  <= 1'b1;
                  resp_q  <= first_q;
                  state_q <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = done_q;
   assign fast_hit  = fast_q;
   assign slow_hit  = slow_q;
   assign miss      = miss_q;
   assign resp_line = RESP_W'(resp_q);
   assign mem_req   = (state_q == ST_REFILL);
   assign mem_addr  = addr_q;
endmodule

// File: rtl/wpc_lookup_chk.sv
module wpc_lookup_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              fast_hit,
   input logic              slow_hit,
   input logic              miss,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr
);
   // R5
   flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot({fast_hit, slow_hit, miss}));

   // R5
   flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !(fast_hit || slow_hit || miss));

   // R2
   fast_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_hit |-> $past(req_valid && req_ready));

   // R3
   second_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_hit || miss) |-> ($past(req_valid && req_ready, 2) && !$past(req_ready)));

   // R4
   miss_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> mem_req);

   // R4
   refill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R4
   refill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_addr));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> !fast_hit);
endmodule

bind wpc_lookup wpc_lookup_chk #(
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .fast_hit  (fast_hit),
   .slow_hit  (slow_hit),
   .miss      (miss),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr)
);

// File: tb/wpc_lookup_tb.sv
`timescale 1ns/1ps
module wpc_lookup_tb;
   localparam int AW = 6;
   localparam int SW = 2;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;

   logic          rv  [2];
   logic [AW-1:0] ra  [2];
   logic          ack [2];
   logic          rdy [2];
   logic          dn  [2];
   logic          fh  [2];
   logic          sh  [2];
   logic          ms  [2];
   logic [SW:0]   rl  [2];
   logic          mrq [2];
   logic [AW-1:0] ma  [2];

   wpc_lookup #(.ADDR_W(AW), .SET_W(SW), .PSEUDO(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_addr(ra[0]),
      .req_ready(rdy[0]), .done(dn[0]), .fast_hit(fh[0]), .slow_hit(sh[0]),
      .miss(ms[0]), .resp_line(rl[0]), .mem_req(mrq[0]), .mem_addr(ma[0]),
      .mem_ack(ack[0]));

   wpc_lookup #(.ADDR_W(AW), .SET_W(SW), .PSEUDO(1'b1)) u_dut_pseudo (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_addr(ra[1]),
      .req_ready(rdy[1]), .done(dn[1]), .fast_hit(fh[1]), .slow_hit(sh[1]),
      .miss(ms[1]), .resp_line(rl[1]), .mem_req(mrq[1]), .mem_addr(ma[1]),
      .mem_ack(ack[1]));

   // reference model: mode 0 = way-predicted (8 lines), mode 1 = pseudo (4 lines)
   bit         mv [2][8];
   logic [4:0] mk [2][8];
   bit         mp [4];

   int checks = 0;
   int fails  = 0;
   int cur_mode = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s mode%0d %s: actual=%0d expected=%0d",
                  req, cur_mode, what, act, exp);
      end
   endtask

   // outcome codes: 0 fast, 1 slow, 2 miss, 9 malformed
   task automatic access(input int m, input logic [AW-1:0] a, output int cls,
                         output int line);
      int s, f, sc, ecls, eres, obs, nflags;
      logic [4:0] k;
      bit tv;
      logic [4:0] tk;
      cur_mode = m;
      s = int'(a[1:0]);
      k = a[5:1];                                  // R11 key field
      if (m == 0) begin
         f  = int'(mp[s]) * 4 + s;
         sc = (1 - int'(mp[s])) * 4 + s;
      end else begin
         f  = s;
         sc = s ^ 2;
      end
      if (mv[m][f] && mk[m][f] == k)        ecls = 0;
      else if (mv[m][sc] && mk[m][sc] == k) ecls = 1;
      else                                  ecls = 2;
      eres = (ecls == 1 && m == 0) ? sc : f;

      @(negedge clk);
      chk(rdy[m] == 1'b1, "R4", "ready before request", int'(rdy[m]), 1);
      rv[m] = 1'b1;
      ra[m] = a;
      @(negedge clk);
      rv[m] = 1'b0;
      if (dn[m]) begin
         obs = fh[m] ? 0 : 9;
      end else begin
         nflags = int'(fh[m]) + int'(sh[m]) + int'(ms[m]);
         chk(nflags == 0, "R5", "flags without done", nflags, 0);
         @(negedge clk);
         obs = !dn[m] ? 9 : (sh[m] ? 1 : (ms[m] ? 2 : 9));
      end
      nflags = int'(fh[m]) + int'(sh[m]) + int'(ms[m]);
      chk(dn[m] && nflags == 1, "R5", "one flag with done", nflags, 1);
      chk(obs == ecls, (ecls == 0) ? "R2" : ((ecls == 1) ? "R3" : "R4"),
          "outcome", obs, ecls);
      chk(int'(rl[m]) == eres, "R9", "resp_line", int'(rl[m]), eres);
      line = int'(rl[m]);

      if (mrq[m]) begin
         chk(ma[m] == a && !rdy[m], "R4", "refill address", int'(ma[m]), int'(a));
         rv[m] = 1'b1;                              // offered while busy
         ra[m] = ~a;
         @(negedge clk);
         chk(!dn[m] && mrq[m] && ma[m] == a, "R10", "busy request ignored",
             int'(ma[m]), int'(a));
         rv[m]  = 1'b0;
         ack[m] = 1'b1;
         @(negedge clk);
         ack[m] = 1'b0;
         chk(rdy[m] && !mrq[m], "R4", "ready after ack", int'(rdy[m]), 1);
      end

      if (ecls == 1) begin
         if (m == 0) begin
            mp[s] = ~mp[s];
         end else begin
            tv = mv[m][f]; tk = mk[m][f];
            mv[m][f] = 1'b1; mk[m][f] = k;
            mv[m][sc] = tv;  mk[m][sc] = tk;
         end
      end else if (ecls == 2) begin
         mv[m][sc] = mv[m][f]; mk[m][sc] = mk[m][f];
         mv[m][f] = 1'b1;      mk[m][f] = k;
      end
      cls = obs;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int c, ln;
      logic [7:0] lfsr;
      for (int m = 0; m < 2; m++) begin
         rv[m] = 1'b0; ra[m] = '0; ack[m] = 1'b0;
         for (int i = 0; i < 8; i++) begin mv[m][i] = 1'b0; mk[m][i] = '0; end
      end
      for (int i = 0; i < 4; i++) mp[i] = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         cur_mode = m;
         chk(rdy[m] && !dn[m] && !mrq[m], "R1", "reset state", int'(rdy[m]), 1);
      end

      for (int m = 0; m < 2; m++) begin
         // pair sharing index 1: A, B, C differ only in key
         access(m, 6'h01, c, ln); chk(c == 2, "R1", "first access misses", c, 2);
         access(m, 6'h01, c, ln); chk(c == 0, "R2", "repeat is fast", c, 0);
         access(m, 6'h05, c, ln); chk(c == 2, "R8", "conflict miss", c, 2);
         access(m, 6'h01, c, ln); chk(c == 1, "R8", "displaced block slow", c, 1);
         chk(ln == ((m == 0) ? 5 : 1), (m == 0) ? "R6" : "R7", "slow line", ln,
             (m == 0) ? 5 : 1);
         access(m, 6'h01, c, ln);
         chk(c == 0, (m == 0) ? "R6" : "R7", "fast after slow", c, 0);
         access(m, 6'h09, c, ln); chk(c == 2, "R8", "third block", c, 2);
         access(m, 6'h05, c, ln); chk(c == 2, "R8", "old alternate dropped", c, 2);
         // index-bit pairing: E, F share index 0
         access(m, 6'h00, c, ln); chk(c == 2, "R11", "E miss", c, 2);
         access(m, 6'h08, c, ln); chk(c == 2 && ln == 0, "R11", "F miss line", ln, 0);
         access(m, 6'h00, c, ln);
         chk(c == 1 && ln == ((m == 0) ? 4 : 0), "R11", "E in alternate", ln,
             (m == 0) ? 4 : 0);
      end

      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 64; i++) access(m, AW'(i), c, ln);
         for (int i = 63; i >= 0; i--) access(m, AW'(i), c, ln);
         lfsr = 8'hA5;
         for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            access(m, lfsr[5:0] & ((i % 3 == 0) ? 6'h13 : 6'h3F), c, ln);
         end
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule